// File: doc/BRIEF.md
# Single-Word Read Response Extractor

This block sits on the host side of a byte-serial command link. The host first sends a single-word read command. The shifter then hands this block the bytes it clocks back, one byte per valid cycle. A start pulse begins each transaction. At that pulse the block latches three things: the opcode that was sent, a relaxed-mode flag and a CRC-enable flag. It then walks through the response in this order:

- an echo of the opcode;
- a status byte;
- a short run of filler bytes, ended by a start marker;
- four payload bytes;
- optionally, a two-byte CRC-16 trailer.

At the end it pulses `done_o` for one cycle. In that cycle it presents the assembled 32-bit word, an error flag and a two-bit cause code.

Relaxed mode is meant for registers that answer without a running core clock. Their echo, status and CRC cannot be trusted, so relaxed mode drops those checks. The search for the start marker still applies. Bytes that arrive while no transaction is open are dropped.

Top module: `rsp_word_extractor`

## Requirements
- R1: When relaxed mode is off, a first response byte that differs from the latched opcode ends the transaction: `done_o` pulses one cycle after that byte, `err_o`=1 and `err_cause_o`=1 (header fault).
- R2: When relaxed mode is off, a second response byte other than 0x00 ends the transaction with `err_o`=1 and `err_cause_o`=1, one cycle after that byte.
- R3: After the status byte, the block examines up to 8 bytes. The first byte whose upper nibble is 0xF is the start marker, and every earlier byte is skipped. A marker that arrives after 7 fillers is still accepted.
- R4: If none of the 8 examined bytes has upper nibble 0xF, `done_o` pulses one cycle after the eighth byte, with `err_o`=1 and `err_cause_o`=2 (missing start).
- R5: The 4 bytes after the marker form `word_o`, and the first of them is bits 7:0. Cycles with `byte_vld_i` low are stalls and consume nothing.
- R6: With CRC checking active (CRC enable set, relaxed off), two more bytes follow the data, high byte first. They are compared against CRC-16 with polynomial 0x1021 and seed 0xFFFF, fed MSB-first over the 4 data bytes in arrival order. A mismatch gives `err_o`=1 and `err_cause_o`=3. A match gives `err_o`=0 and `err_cause_o`=0.
- R7: With CRC enable clear, `done_o` pulses one cycle after the fourth data byte, with no error.
- R8: In relaxed mode the echo, status and CRC checks are skipped, and `done_o` pulses one cycle after the fourth data byte. A missing marker still ends the transaction with `err_cause_o`=2.
- R9: `done_o` is high for exactly one cycle per transaction. `err_o` and `err_cause_o` are valid in that cycle and hold until the next start pulse.
- R10: A start pulse clears `word_o`, `err_o`, `err_cause_o` and `done_o` in the next cycle and begins a new transaction. Any byte offered in the start cycle is dropped.
- R11: After `done_o`, bytes offered before the next start pulse change neither `word_o` nor the flags, and raise no `done_o`.
- R12: After reset, `done_o`, `err_o`, `err_cause_o` and `word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens a transaction and latches the mode inputs |
| opcode_i | input | 8 | Opcode that was sent, compared against the echo |
| relaxed_i | input | 1 | Skip the echo, status and CRC checks |
| crc_en_i | input | 1 | Expect and verify a CRC-16 trailer |
| byte_vld_i | input | 1 | `byte_i` carries a received byte this cycle |
| byte_i | input | 8 | Received byte |
| word_o | output | 32 | Assembled data word, first data byte in bits 7:0 |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | Transaction ended in error |
| err_cause_o | output | 2 | 0 none, 1 header, 2 missing start, 3 CRC |

## Verification
The properties assume that `start_i` is a single-cycle pulse, and that the mode inputs are steady in the cycle it is high. They also assume no transaction is abandoned by an overlapping start except on purpose. The bench meets these conditions by driving every input on the falling edge from one task at a time. Each scenario task raises start alone for one cycle, then offers only the bytes of its own response, with optional idle gaps between them. Extra bytes are offered after a transaction only in the scenario that deliberately probes how they are ignored.

// File: rtl/rwx_pkg.sv
// Shared types for the read response extractor.
// Assumes: one transaction at a time; states and causes are fixed encodings.
package rwx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ECHO,
        ST_STAT,
        ST_SCAN,
        ST_DATA,
        ST_CRCH,
        ST_CRCL
    } rwx_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_HDR     = 2'd1,
        CAUSE_NOSTART = 2'd2,
        CAUSE_CRC     = 2'd3
    } rwx_cause_e;

    localparam logic [7:0] STATUS_GOOD = 8'h00;
    localparam logic [3:0] MARKER_TAG  = 4'hF;

endpackage

// File: rtl/rwx_crc16.sv
// Serial CRC-16 over bytes, MSB first, one byte per step.
// Assumes: clear_i reloads the seed and takes priority over step_i.
module rwx_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    input  logic        step_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;
    logic [15:0] crc_next;

    // Fold one byte into the register, eight shifts deep.
    always_comb begin
        crc_next = crc_q;
        for (int i = 7; i >= 0; i--) begin
            if (crc_next[15] ^ byte_i[i]) begin
                crc_next = {crc_next[14:0], 1'b0} ^ POLY;
            end else begin
                crc_next = {crc_next[14:0], 1'b0};
            end
        end
    end

    // Hold the running remainder; reload at reset or transaction start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            crc_q <= SEED;
        end else if (step_i) begin
            crc_q <= crc_next;
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/rwx_scan_window.sv
// Counts filler slots while searching for the start marker.
// Assumes: step_i is raised only for bytes inside the search window.
module rwx_scan_window #(
    parameter int          WIN = 8,
    parameter logic [3:0]  TAG = 4'hF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic [3:0] tag_i,
    output logic       hit_o,
    output logic       last_o
);

    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] slot_q;

    // Slot index of the byte under test; saturates at the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            slot_q <= '0;
        end else if (step_i && !last_o) begin
            slot_q <= slot_q + CW'(1);
        end
    end

    assign hit_o  = (tag_i == TAG);
    assign last_o = (slot_q == CW'(WIN - 1));

endmodule

// File: rtl/rwx_word_pack.sv
// Assembles a word from bytes, first byte into the least significant lane.
// Assumes: step_i is raised once per payload byte.
module rwx_word_pack #(
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  step_i,
    input  logic [7:0]            byte_i,
    output logic [8*NBYTES-1:0]   word_o,
    output logic                  last_o
);

    localparam int W  = 8 * NBYTES;
    localparam int CW = $clog2(NBYTES + 1);

    logic [W-1:0]  word_q;
    logic [CW-1:0] cnt_q;

    // Shift each byte in from the top so the first lands at bits 7:0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            word_q <= '0;
        end else if (step_i) begin
            word_q <= {byte_i, word_q[W-1:8]};
        end
    end

    // Count payload bytes taken so far.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign word_o = word_q;
    assign last_o = (cnt_q == CW'(NBYTES - 1));

endmodule

// File: rtl/rsp_word_extractor.sv
// Parses a single-word read response: echo, status, filler scan,
// payload, optional CRC-16 trailer. Reports word, done pulse and cause.
// Assumes: start_i is a one-cycle pulse; modes are steady while it is high.
module rsp_word_extractor
    import rwx_pkg::*;
#(
    parameter int          WORD_BYTES = 4,
    parameter int          SCAN_WIN   = 8,
    parameter logic [15:0] CRC_POLY   = 16'h1021,
    parameter logic [15:0] CRC_SEED   = 16'hFFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [7:0]              opcode_i,
    input  logic                    relaxed_i,
    input  logic                    crc_en_i,
    input  logic                    byte_vld_i,
    input  logic [7:0]              byte_i,
    output logic [8*WORD_BYTES-1:0] word_o,
    output logic                    done_o,
    output logic                    err_o,
    output logic [1:0]              err_cause_o
);

    rwx_state_e state_q;
    rwx_cause_e cause_q;
    logic [7:0] op_q;
    logic       relaxed_q;
    logic       chk_crc_q;
    logic       crc_hi_ok_q;
    logic       done_q;
    logic       busy;
    logic       take;

    logic        scan_step, scan_hit, scan_last;
    logic        data_step, data_last;
    logic [15:0] crc_val;

    assign busy      = (state_q != ST_IDLE);
    assign take      = busy && byte_vld_i && !start_i;
    assign scan_step = take && (state_q == ST_SCAN);
    assign data_step = take && (state_q == ST_DATA);

    rwx_scan_window #(
        .WIN (SCAN_WIN),
        .TAG (MARKER_TAG)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (scan_step),
        .tag_i   (byte_i[7:4]),
        .hit_o   (scan_hit),
        .last_o  (scan_last)
    );

    rwx_word_pack #(
        .NBYTES (WORD_BYTES)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (data_step),
        .byte_i  (byte_i),
        .word_o  (word_o),
        .last_o  (data_last)
    );

    rwx_crc16 #(
        .POLY (CRC_POLY),
        .SEED (CRC_SEED)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (data_step),
        .byte_i  (byte_i),
        .crc_o   (crc_val)
    );

    // Latch the per-transaction modes at the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            relaxed_q <= 1'b0;
            chk_crc_q <= 1'b0;
        end else if (start_i) begin
            op_q      <= opcode_i;
            relaxed_q <= relaxed_i;
            chk_crc_q <= crc_en_i && !relaxed_i;
        end
    end

    // Walk the response byte by byte and close with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cause_q     <= CAUSE_NONE;
            done_q      <= 1'b0;
            crc_hi_ok_q <= 1'b0;
        end else if (start_i) begin
            state_q     <= ST_ECHO;
            cause_q     <= CAUSE_NONE;
            done_q      <= 1'b0;
            crc_hi_ok_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                unique case (state_q)
                    ST_ECHO: begin
                        if (!relaxed_q && byte_i != op_q) begin
                            cause_q <= CAUSE_HDR;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_STAT;
                        end
                    end
                    ST_STAT: begin
                        if (!relaxed_q && byte_i != STATUS_GOOD) begin
                            cause_q <= CAUSE_HDR;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_SCAN;
                        end
                    end
                    ST_SCAN: begin
                        if (scan_hit) begin
                            state_q <= ST_DATA;
                        end else if (scan_last) begin
                            cause_q <= CAUSE_NOSTART;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        if (data_last) begin
                            if (chk_crc_q) begin
                                state_q <= ST_CRCH;
                            end else begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_CRCH: begin
                        crc_hi_ok_q <= (byte_i == crc_val[15:8]);
                        state_q     <= ST_CRCL;
                    end
                    ST_CRCL: begin
                        if (!(crc_hi_ok_q && byte_i == crc_val[7:0])) begin
                            cause_q <= CAUSE_CRC;
                        end
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign done_o      = done_q;
    assign err_o       = (cause_q != CAUSE_NONE);
    assign err_cause_o = cause_q;

endmodule

// File: rtl/rwx_chk.sv
// Temporal checks on the extractor's outputs, attached by bind.
// Assumes: start_i is a single-cycle pulse from the requester.
module rwx_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              done_o,
    input logic              err_o,
    input logic [1:0]        err_cause_o,
    input logic [WORD_W-1:0] word_o,
    input logic              busy,
    input logic              chk_crc_q
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !err_o && word_o == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> ($stable(word_o) && !done_o && $stable(err_cause_o)));

    // R6
    crc_cause_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_cause_o == 2'd3) |-> chk_crc_q);

endmodule

bind rsp_word_extractor rwx_chk #(
    .WORD_W (8 * WORD_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_cause_o (err_cause_o),
    .word_o      (word_o),
    .busy        (busy),
    .chk_crc_q   (chk_crc_q)
);

// File: tb/rsp_word_extractor_tb.sv
module rsp_word_extractor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'hA5;
    logic        relaxed_i = 1'b0;
    logic        crc_en_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [31:0] word_o;
    logic        done_o;
    logic        err_o;
    logic [1:0]  err_cause_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0]  seq [0:23];
    int          seq_len;
    int          pulses;
    logic        got_done;
    logic        got_err;
    logic [1:0]  got_cause;
    logic [31:0] got_word;

    always #2.5 clk = ~clk;

    rsp_word_extractor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .opcode_i    (opcode_i),
        .relaxed_i   (relaxed_i),
        .crc_en_i    (crc_en_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .word_o      (word_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .err_cause_o (err_cause_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [31:0] w);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < 4; k++) begin
            for (int j = 7; j >= 0; j--) begin
                logic fb = c[15] ^ w[8*k + j];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    // Response: echo, status, nfill filler bytes, optional marker, data, optional crc.
    task automatic build(input logic [7:0] echo, input logic [7:0] stat, input int nfill,
                         input logic [7:0] fill, input bit marker, input logic [31:0] w,
                         input bit add_crc, input bit bad_crc);
        logic [15:0] c = ref_crc(w);
        seq_len = 0;
        seq[seq_len++] = echo;
        seq[seq_len++] = stat;
        for (int i = 0; i < nfill; i++) seq[seq_len++] = fill;
        if (marker) begin
            seq[seq_len++] = 8'hF3;
            for (int i = 0; i < 4; i++) seq[seq_len++] = w[8*i +: 8];
            if (add_crc) begin
                if (bad_crc) c = c ^ 16'h0100;
                seq[seq_len++] = c[15:8];
                seq[seq_len++] = c[7:0];
            end
        end
    endtask

    // Pulse start, offer seq[0..n-1], record outputs the cycle after byte n-1.
    task automatic play(input int n, input bit gaps);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                byte_vld_i = 1'b0;
                byte_i = 8'hFF;
                @(negedge clk);
                pulses += int'(done_o);
            end
            byte_vld_i = 1'b1;
            byte_i = seq[i];
            @(negedge clk);
            pulses += int'(done_o);
        end
        byte_vld_i = 1'b0;
        got_done  = done_o;
        got_err   = err_o;
        got_cause = err_cause_o;
        got_word  = word_o;
        @(negedge clk);
        pulses += int'(done_o);
    endtask

    task automatic expect_end(input string req, input bit e, input logic [1:0] cause,
                              input bit chk_word, input logic [31:0] w);
        check(got_done == 1'b1, {req, " done after last byte"}, 32'(got_done), 32'd1);
        check(pulses == 1, {req, " single done pulse"}, 32'(pulses), 32'd1);
        check(got_err == e, {req, " err"}, 32'(got_err), 32'(e));
        check(got_cause == cause, {req, " cause"}, 32'(got_cause), 32'(cause));
        if (chk_word) check(got_word == w, {req, " word"}, got_word, w);
    endtask

    task automatic t_reset();
        check(done_o == 1'b0 && err_o == 1'b0, "R12 flags after reset", {30'd0, done_o, err_o}, 32'd0);
        check(err_cause_o == 2'd0, "R12 cause after reset", 32'(err_cause_o), 32'd0);
        check(word_o == 32'd0, "R12 word after reset", word_o, 32'd0);
    endtask

    task automatic t_plain();
        relaxed_i = 0; crc_en_i = 0;
        build(8'hA5, 8'h00, 0, 8'h00, 1, 32'h1234_5678, 0, 0);
        play(seq_len, 0);
        expect_end("R5 R7 R9 plain read", 0, 2'd0, 1, 32'h1234_5678);
    endtask

    task automatic t_fill_crc_good();
        relaxed_i = 0; crc_en_i = 1;
        build(8'hA5, 8'h00, 3, 8'h00, 1, 32'hCAFE_0F1E, 1, 0);
        play(seq_len, 1);
        expect_end("R3 R6 fillers with good crc and stalls", 0, 2'd0, 1, 32'hCAFE_0F1E);
    endtask

    task automatic t_fill_edge();
        relaxed_i = 0; crc_en_i = 0;
        build(8'hA5, 8'h00, 7, 8'hE5, 1, 32'h0BAD_F00D, 0, 0);
        play(seq_len, 0);
        expect_end("R3 marker after 7 fillers", 0, 2'd0, 1, 32'h0BAD_F00D);
    endtask

    task automatic t_nostart();
        relaxed_i = 0; crc_en_i = 0;
        build(8'hA5, 8'h00, 8, 8'h00, 0, 32'd0, 0, 0);
        play(seq_len, 0);
        expect_end("R4 eight fillers no marker", 1, 2'd2, 0, 32'd0);
    endtask

    task automatic t_echo_bad();
        relaxed_i = 0; crc_en_i = 0;
        build(8'h5A, 8'h00, 0, 8'h00, 1, 32'h1111_2222, 0, 0);
        play(1, 0);
        expect_end("R1 echo mismatch", 1, 2'd1, 0, 32'd0);
    endtask

    task automatic t_status_bad();
        relaxed_i = 0; crc_en_i = 0;
        build(8'hA5, 8'h04, 0, 8'h00, 1, 32'h1111_2222, 0, 0);
        play(2, 0);
        expect_end("R2 status nonzero", 1, 2'd1, 0, 32'd0);
    endtask

    task automatic t_crc_bad_then_idle();
        relaxed_i = 0; crc_en_i = 1;
        build(8'hA5, 8'h00, 1, 8'h00, 1, 32'h8899_AABB, 1, 1);
        play(seq_len, 0);
        expect_end("R6 crc mismatch", 1, 2'd3, 1, 32'h8899_AABB);
        // Bytes after done must be dropped.
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            byte_vld_i = 1'b1;
            byte_i = 8'hF0 + 8'(i);
            @(negedge clk);
            pulses += int'(done_o);
        end
        byte_vld_i = 1'b0;
        check(pulses == 0, "R11 no done from stray bytes", 32'(pulses), 32'd0);
        check(word_o == 32'h8899_AABB, "R11 word held", word_o, 32'h8899_AABB);
        check(err_cause_o == 2'd3, "R9 cause held until start", 32'(err_cause_o), 32'd3);
        // A start pulse clears everything, with a byte offered in the same cycle.
        start_i = 1'b1;
        byte_vld_i = 1'b1;
        byte_i = 8'hA5;
        @(negedge clk);
        start_i = 1'b0;
        byte_vld_i = 1'b0;
        check(word_o == 32'd0 && err_o == 1'b0 && done_o == 1'b0, "R10 start clears",
              word_o | 32'(err_o), 32'd0);
        check(err_cause_o == 2'd0, "R10 cause cleared", 32'(err_cause_o), 32'd0);
        // The byte in the start cycle was dropped: an echo is still expected first.
        build(8'hA5, 8'h00, 0, 8'h00, 1, 32'h0102_0304, 1, 0);
        pulses = 0;
        for (int i = 0; i < seq_len; i++) begin
            byte_vld_i = 1'b1;
            byte_i = seq[i];
            @(negedge clk);
            pulses += int'(done_o);
        end
        byte_vld_i = 1'b0;
        check(done_o == 1'b1 && err_o == 1'b0, "R10 fresh transaction after start",
              {30'd0, done_o, err_o}, 32'd2);
        check(word_o == 32'h0102_0304, "R10 fresh word", word_o, 32'h0102_0304);
        @(negedge clk);
    endtask

    task automatic t_relaxed();
        relaxed_i = 1; crc_en_i = 1;
        build(8'h3C, 8'h55, 2, 8'h00, 1, 32'hDEAD_BEEF, 0, 0);
        play(seq_len, 0);
        expect_end("R8 relaxed skips echo status crc", 0, 2'd0, 1, 32'hDEAD_BEEF);
        build(8'h3C, 8'h55, 8, 8'h12, 0, 32'd0, 0, 0);
        play(seq_len, 0);
        expect_end("R8 relaxed still needs marker", 1, 2'd2, 0, 32'd0);
        relaxed_i = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_fill_crc_good();
        t_fill_edge();
        t_nostart();
        t_echo_bad();
        t_status_bad();
        t_crc_bad_then_idle();
        t_relaxed();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule